// File: doc/BRIEF.md
# Dual-loop vector step sequencer

This block keeps the loop position of a vector instruction for its source and its destination sides. Each side has two counters: an element step and a sub-element step. On every cycle where the advance strobe is high, both sides move one position through a two-level nested loop. The sub-vector length input sets how far the sub-element loop runs. A per-side end flag, computed outside this block, marks the last element.

Each side nests its loops in one of two ways, chosen at run time. In normal order, the sub-element loop is the inner loop. When the source pack control or the destination unpack control is set, that side inverts its order: the element loop becomes the inner one, and the sub-element counter only moves when an element pass finishes. The two sides choose their order independently.

A per-side load port writes both counters of that side directly. An external unit, such as one that skips masked-off elements, uses it to place the loop position.

Top module: `vec_step_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all four counters to 0 on the following cycle, overriding load and advance.
- R2: On a cycle with `adv` low and the side's load low, both counters of that side keep their values.
- R3: Normal order (order control 0), `adv` high, side sub-step equal to `sub_len`: the sub-step becomes 0. The element step increments by one if the side's end flag is 0, and keeps its value if the flag is 1.
- R4: Normal order, `adv` high, side sub-step not equal to `sub_len`: the sub-step increments by one and the element step is unchanged.
- R5: Inverted order (order control 1), `adv` high, side end flag 1: the element step becomes 0. The sub-step increments by one if it is not equal to `sub_len`, and keeps its value if it is.
- R6: Inverted order, `adv` high, side end flag 0: the element step increments by one and the sub-step is unchanged.
- R7: The source side takes its order from `src_pack` and its end flag from `src_end`. The destination side takes its order from `dst_unpack` and its end flag from `dst_end`. Neither side's controls affect the other side.
- R8: When a side's load input is high (and `rst` low), that side's element and sub-step take the load values on the next cycle, whatever `adv` is. The other side follows its own rules.
- R9: Counters wrap modulo their width: the element step goes from 2^ELEM_W-1 to 0, and the sub-step goes from 2^SUB_W-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| adv | input | 1 | Advance strobe, one loop step per high cycle |
| sub_len | input | SUB_W | Last sub-step value of the sub-element loop |
| src_end | input | 1 | Source end-of-element flag |
| dst_end | input | 1 | Destination end-of-element flag |
| src_pack | input | 1 | Source order: 1 puts the sub-element loop outside |
| dst_unpack | input | 1 | Destination order: 1 puts the sub-element loop outside |
| src_load | input | 1 | Write the source counters from the load values |
| src_load_elem | input | ELEM_W | Source element step load value |
| src_load_sub | input | SUB_W | Source sub-step load value |
| dst_load | input | 1 | Write the destination counters from the load values |
| dst_load_elem | input | ELEM_W | Destination element step load value |
| dst_load_sub | input | SUB_W | Destination sub-step load value |
| src_elem | output | ELEM_W | Source element step |
| src_sub | output | SUB_W | Source sub-step |
| dst_elem | output | ELEM_W | Destination element step |
| dst_sub | output | SUB_W | Destination sub-step |

## Verification
The bench builds the block with the default widths: a 7-bit element step and a 2-bit sub-step. With these widths, the load port can place a counter at 127 or 3 and reach both wrap points in a single step. All four `sub_len` values can be driven, including 3, where the sub-step wraps only through its equality test. Directed phases set the two order controls to opposite values so that each side's rules are seen apart from the other's. A long random phase then mixes loads, end flags and strobe gaps against the behavioural model.

// File: rtl/vss_pkg.sv
package vss_pkg;

  localparam int NUM_SIDES = 2;
  localparam int SIDE_SRC  = 0;
  localparam int SIDE_DST  = 1;

  // Per-cycle counter actions for one side.
  typedef struct packed {
    logic elem_inc;
    logic elem_clr;
    logic sub_inc;
    logic sub_clr;
  } step_cmd_t;

  // Decide the counter actions for one advance.
  function automatic step_cmd_t plan_step(input logic invert,
                                          input logic sub_at_end,
                                          input logic elem_end);
    step_cmd_t c;
    c = '0;
    if (!invert) begin
      if (sub_at_end) begin
        c.sub_clr  = 1'b1;
        c.elem_inc = !elem_end;
      end else begin
        c.sub_inc  = 1'b1;
      end
    end else begin
      if (elem_end) begin
        c.elem_clr = 1'b1;
        c.sub_inc  = !sub_at_end;
      end else begin
        c.elem_inc = 1'b1;
      end
    end
    return c;
  endfunction

endpackage

// File: rtl/vss_next.sv
module vss_next
  import vss_pkg::*;
#(
  parameter int ELEM_W = 7,
  parameter int SUB_W  = 2
) (
  input  logic [ELEM_W-1:0] elem_q,
  input  logic [SUB_W-1:0]  sub_q,
  input  logic [SUB_W-1:0]  sub_len,
  input  logic              elem_end,
  input  logic              invert,
  input  logic              adv,
  input  logic              load,
  input  logic [ELEM_W-1:0] load_elem,
  input  logic [SUB_W-1:0]  load_sub,
  output logic [ELEM_W-1:0] elem_d,
  output logic [SUB_W-1:0]  sub_d,
  output step_cmd_t         cmd,
  output logic              sub_at_end
);

  localparam logic [ELEM_W-1:0] ELEM_ONE = ELEM_W'(1);
  localparam logic [SUB_W-1:0]  SUB_ONE  = SUB_W'(1);

  function automatic logic [ELEM_W-1:0] elem_apply(input logic [ELEM_W-1:0] v,
                                                   input logic clr,
                                                   input logic inc);
    if (clr)      return '0;
    else if (inc) return v + ELEM_ONE;
    else          return v;
  endfunction

  function automatic logic [SUB_W-1:0] sub_apply(input logic [SUB_W-1:0] v,
                                                 input logic clr,
                                                 input logic inc);
    if (clr)      return '0;
    else if (inc) return v + SUB_ONE;
    else          return v;
  endfunction

  step_cmd_t planned;

  assign sub_at_end = (sub_q == sub_len);
  assign planned    = plan_step(invert, sub_at_end, elem_end);

  always_comb begin
    cmd = '0;
    if (adv && !load) cmd = planned;
  end

  always_comb begin
    if (load) begin
      elem_d = load_elem;
      sub_d  = load_sub;
    end else begin
      elem_d = elem_apply(elem_q, cmd.elem_clr, cmd.elem_inc);
      sub_d  = sub_apply(sub_q, cmd.sub_clr, cmd.sub_inc);
    end
  end

endmodule

// File: rtl/vss_side.sv
module vss_side
  import vss_pkg::*;
#(
  parameter int ELEM_W = 7,
  parameter int SUB_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic [SUB_W-1:0]  sub_len,
  input  logic              elem_end,
  input  logic              invert,
  input  logic              load,
  input  logic [ELEM_W-1:0] load_elem,
  input  logic [SUB_W-1:0]  load_sub,
  output logic [ELEM_W-1:0] elem,
  output logic [SUB_W-1:0]  sub,
  output step_cmd_t         cmd,
  output logic              sub_at_end
);

  logic [ELEM_W-1:0] elem_d;
  logic [SUB_W-1:0]  sub_d;

  vss_next #(.ELEM_W(ELEM_W), .SUB_W(SUB_W)) u_next (
    .elem_q    (elem),
    .sub_q     (sub),
    .sub_len   (sub_len),
    .elem_end  (elem_end),
    .invert    (invert),
    .adv       (adv),
    .load      (load),
    .load_elem (load_elem),
    .load_sub  (load_sub),
    .elem_d    (elem_d),
    .sub_d     (sub_d),
    .cmd       (cmd),
    .sub_at_end(sub_at_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      elem <= '0;
      sub  <= '0;
    end else begin
      elem <= elem_d;
      sub  <= sub_d;
    end
  end

endmodule

// File: rtl/vec_step_seq.sv
module vec_step_seq
  import vss_pkg::*;
#(
  parameter int ELEM_W = 7,
  parameter int SUB_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic [SUB_W-1:0]  sub_len,
  input  logic              src_end,
  input  logic              dst_end,
  input  logic              src_pack,
  input  logic              dst_unpack,
  input  logic              src_load,
  input  logic [ELEM_W-1:0] src_load_elem,
  input  logic [SUB_W-1:0]  src_load_sub,
  input  logic              dst_load,
  input  logic [ELEM_W-1:0] dst_load_elem,
  input  logic [SUB_W-1:0]  dst_load_sub,
  output logic [ELEM_W-1:0] src_elem,
  output logic [SUB_W-1:0]  src_sub,
  output logic [ELEM_W-1:0] dst_elem,
  output logic [SUB_W-1:0]  dst_sub
);

  logic [NUM_SIDES-1:0]             side_end;
  logic [NUM_SIDES-1:0]             side_inv;
  logic [NUM_SIDES-1:0]             side_load;
  logic [NUM_SIDES-1:0][ELEM_W-1:0] side_load_elem;
  logic [NUM_SIDES-1:0][SUB_W-1:0]  side_load_sub;
  logic [NUM_SIDES-1:0][ELEM_W-1:0] side_elem;
  logic [NUM_SIDES-1:0][SUB_W-1:0]  side_sub;
  step_cmd_t [NUM_SIDES-1:0]        side_cmd;
  logic [NUM_SIDES-1:0]             side_sub_end;

  // Named internal events, brought out for the checker.
  logic src_sub_end, dst_sub_end;
  step_cmd_t src_cmd, dst_cmd;

  assign side_end[SIDE_SRC]       = src_end;
  assign side_end[SIDE_DST]       = dst_end;
  assign side_inv[SIDE_SRC]       = src_pack;
  assign side_inv[SIDE_DST]       = dst_unpack;
  assign side_load[SIDE_SRC]      = src_load;
  assign side_load[SIDE_DST]      = dst_load;
  assign side_load_elem[SIDE_SRC] = src_load_elem;
  assign side_load_elem[SIDE_DST] = dst_load_elem;
  assign side_load_sub[SIDE_SRC]  = src_load_sub;
  assign side_load_sub[SIDE_DST]  = dst_load_sub;

  generate
    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
      vss_side #(.ELEM_W(ELEM_W), .SUB_W(SUB_W)) u_side (
        .clk       (clk),
        .rst       (rst),
        .adv       (adv),
        .sub_len   (sub_len),
        .elem_end  (side_end[g]),
        .invert    (side_inv[g]),
        .load      (side_load[g]),
        .load_elem (side_load_elem[g]),
        .load_sub  (side_load_sub[g]),
        .elem      (side_elem[g]),
        .sub       (side_sub[g]),
        .cmd       (side_cmd[g]),
        .sub_at_end(side_sub_end[g])
      );
    end
  endgenerate

  assign src_elem    = side_elem[SIDE_SRC];
  assign src_sub     = side_sub[SIDE_SRC];
  assign dst_elem    = side_elem[SIDE_DST];
  assign dst_sub     = side_sub[SIDE_DST];
  assign src_sub_end = side_sub_end[SIDE_SRC];
  assign dst_sub_end = side_sub_end[SIDE_DST];
  assign src_cmd     = side_cmd[SIDE_SRC];
  assign dst_cmd     = side_cmd[SIDE_DST];

endmodule

// File: rtl/vss_checker.sv
module vss_checker
  import vss_pkg::*;
#(
  parameter int ELEM_W = 7,
  parameter int SUB_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              adv,
  input logic [SUB_W-1:0]  sub_len,
  input logic              src_end,
  input logic              dst_end,
  input logic              src_pack,
  input logic              dst_unpack,
  input logic              src_load,
  input logic [ELEM_W-1:0] src_load_elem,
  input logic [SUB_W-1:0]  src_load_sub,
  input logic              dst_load,
  input logic [ELEM_W-1:0] dst_load_elem,
  input logic [SUB_W-1:0]  dst_load_sub,
  input logic [ELEM_W-1:0] src_elem,
  input logic [SUB_W-1:0]  src_sub,
  input logic [ELEM_W-1:0] dst_elem,
  input logic [SUB_W-1:0]  dst_sub,
  input step_cmd_t         src_cmd,
  input step_cmd_t         dst_cmd
);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (src_elem == '0 && src_sub == '0 && dst_elem == '0 && dst_sub == '0)); // R1

  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (rst) (!adv && !src_load) |=> ($stable(src_elem) && $stable(src_sub))); // R2

  AST_DST_HOLD: assert property (@(posedge clk) disable iff (rst) (!adv && !dst_load) |=> ($stable(dst_elem) && $stable(dst_sub))); // R2

  AST_SRC_INNER_WRAP: assert property (@(posedge clk) disable iff (rst) (adv && !src_load && !src_pack && src_sub == sub_len) |=> (src_sub == '0)); // R3

  AST_DST_INNER_STEP: assert property (@(posedge clk) disable iff (rst) (adv && !dst_load && !dst_unpack && dst_sub != sub_len) |=> (dst_sub == SUB_W'($past(dst_sub) + 1'b1) && $stable(dst_elem))); // R4

  AST_SRC_OUTER_CLEAR: assert property (@(posedge clk) disable iff (rst) (adv && !src_load && src_pack && src_end) |=> (src_elem == '0)); // R5

  AST_DST_OUTER_STEP: assert property (@(posedge clk) disable iff (rst) (adv && !dst_load && dst_unpack && !dst_end) |=> (dst_elem == ELEM_W'($past(dst_elem) + 1'b1) && $stable(dst_sub))); // R6

  AST_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) ($onehot0({src_cmd.elem_inc, src_cmd.elem_clr}) && $onehot0({dst_cmd.sub_inc, dst_cmd.sub_clr}))); // R7

  AST_SRC_LOAD: assert property (@(posedge clk) disable iff (rst) src_load |=> (src_elem == $past(src_load_elem) && src_sub == $past(src_load_sub))); // R8

  AST_DST_LOAD: assert property (@(posedge clk) disable iff (rst) dst_load |=> (dst_elem == $past(dst_load_elem) && dst_sub == $past(dst_load_sub))); // R8

endmodule

bind vec_step_seq vss_checker #(.ELEM_W(ELEM_W), .SUB_W(SUB_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .adv          (adv),
  .sub_len      (sub_len),
  .src_end      (src_end),
  .dst_end      (dst_end),
  .src_pack     (src_pack),
  .dst_unpack   (dst_unpack),
  .src_load     (src_load),
  .src_load_elem(src_load_elem),
  .src_load_sub (src_load_sub),
  .dst_load     (dst_load),
  .dst_load_elem(dst_load_elem),
  .dst_load_sub (dst_load_sub),
  .src_elem     (src_elem),
  .src_sub      (src_sub),
  .dst_elem     (dst_elem),
  .dst_sub      (dst_sub),
  .src_cmd      (src_cmd),
  .dst_cmd      (dst_cmd)
);

// File: tb/vec_step_seq_test.sv
`timescale 1ns/1ps
module vec_step_seq_test;

  localparam int EW = 7;
  localparam int SW = 2;
  localparam int EMOD = 1 << EW;
  localparam int SMOD = 1 << SW;

  logic          clk = 1'b0;
  logic          rst, adv, src_end, dst_end, src_pack, dst_unpack;
  logic [SW-1:0] sub_len;
  logic          src_load, dst_load;
  logic [EW-1:0] src_load_elem, dst_load_elem;
  logic [SW-1:0] src_load_sub, dst_load_sub;
  logic [EW-1:0] src_elem, dst_elem;
  logic [SW-1:0] src_sub, dst_sub;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vec_step_seq #(.ELEM_W(EW), .SUB_W(SW)) uut (
    .clk(clk), .rst(rst), .adv(adv), .sub_len(sub_len),
    .src_end(src_end), .dst_end(dst_end),
    .src_pack(src_pack), .dst_unpack(dst_unpack),
    .src_load(src_load), .src_load_elem(src_load_elem), .src_load_sub(src_load_sub),
    .dst_load(dst_load), .dst_load_elem(dst_load_elem), .dst_load_sub(dst_load_sub),
    .src_elem(src_elem), .src_sub(src_sub), .dst_elem(dst_elem), .dst_sub(dst_sub)
  );

  // Behavioural reference: index 0 source, 1 destination.
  int    m_e[2];
  int    m_s[2];
  string m_tag[2];
  bit    m_valid = 0;

  always @(posedge clk) begin
    bit    inv, fin, ld;
    int    le, ls;
    for (int k = 0; k < 2; k++) begin
      inv = (k == 0) ? src_pack : dst_unpack;
      fin = (k == 0) ? src_end : dst_end;
      ld  = (k == 0) ? src_load : dst_load;
      le  = (k == 0) ? int'(src_load_elem) : int'(dst_load_elem);
      ls  = (k == 0) ? int'(src_load_sub) : int'(dst_load_sub);
      if (rst) begin
        m_e[k] = 0; m_s[k] = 0; m_tag[k] = "R1";
      end else if (ld) begin
        m_e[k] = le; m_s[k] = ls; m_tag[k] = "R8";
      end else if (!adv) begin
        m_tag[k] = "R2";
      end else if (!inv) begin
        if (m_s[k] == int'(sub_len)) begin
          m_s[k] = 0;
          if (!fin) m_e[k] = (m_e[k] + 1) % EMOD;
          m_tag[k] = "R3";
        end else begin
          m_s[k] = (m_s[k] + 1) % SMOD;
          m_tag[k] = "R4";
        end
      end else begin
        if (fin) begin
          if (m_s[k] != int'(sub_len)) m_s[k] = (m_s[k] + 1) % SMOD;
          m_e[k] = 0;
          m_tag[k] = "R5";
        end else begin
          m_e[k] = (m_e[k] + 1) % EMOD;
          m_tag[k] = "R6";
        end
      end
    end
    if (rst) m_valid = 1;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (m_valid && !done) begin
      chk({m_tag[0], " src_elem"}, int'(src_elem), m_e[0]);
      chk({m_tag[0], " src_sub"},  int'(src_sub),  m_s[0]);
      chk({m_tag[1], " dst_elem"}, int'(dst_elem), m_e[1]);
      chk({m_tag[1], " dst_sub"},  int'(dst_sub),  m_s[1]);
    end
  end

  task automatic idle_inputs();
    adv = 0; src_end = 0; dst_end = 0; src_pack = 0; dst_unpack = 0;
    src_load = 0; dst_load = 0; src_load_elem = '0; dst_load_elem = '0;
    src_load_sub = '0; dst_load_sub = '0;
  endtask

  task automatic cyc(bit a, bit se, bit de);
    @(negedge clk);
    adv = a; src_end = se; dst_end = de;
  endtask

  task automatic load_both(int se, int ss, int de, int ds);
    @(negedge clk);
    adv = 0; src_load = 1; dst_load = 1;
    src_load_elem = EW'(se); src_load_sub = SW'(ss);
    dst_load_elem = EW'(de); dst_load_sub = SW'(ds);
    @(negedge clk);
    src_load = 0; dst_load = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
    end
  end

  initial begin
    idle_inputs();
    sub_len = 2'd2;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 reset src_elem", int'(src_elem), 0);
    chk("R1 reset dst_sub", int'(dst_sub), 0);

    // R2 hold with no strobe
    repeat (3) cyc(0, 1, 1);

    // Normal order both sides, sub_len 2: R3 and R4
    for (int i = 0; i < 12; i++) cyc(1, (i % 5) == 4, (i % 7) == 6);
    cyc(0, 0, 0);

    // R7 opposite orders: source inverted, destination normal
    load_both(0, 0, 0, 0);
    @(negedge clk); src_pack = 1; dst_unpack = 0; adv = 1; src_end = 0; dst_end = 0;
    @(negedge clk); adv = 0;
    chk("R7 src inverted elem", int'(src_elem), 1);
    chk("R7 src inverted sub", int'(src_sub), 0);
    chk("R7 dst normal elem", int'(dst_elem), 0);
    chk("R7 dst normal sub", int'(dst_sub), 1);
    for (int i = 0; i < 10; i++) cyc(1, (i % 3) == 2, (i % 4) == 3);
    @(negedge clk); src_pack = 0; dst_unpack = 1; adv = 0;
    for (int i = 0; i < 10; i++) cyc(1, (i % 4) == 1, (i % 3) == 0);

    // R5 inverted end with sub at end: sub holds
    @(negedge clk); src_pack = 1; dst_unpack = 1; adv = 0;
    load_both(9, 2, 9, 1);
    @(negedge clk); adv = 1; src_end = 1; dst_end = 1;
    @(negedge clk); adv = 0; src_end = 0; dst_end = 0;
    chk("R5 sub held at end", int'(src_sub), 2);
    chk("R5 sub stepped", int'(dst_sub), 2);
    chk("R5 elem cleared", int'(dst_elem), 0);

    // R9 wrap of element step
    load_both(127, 0, 127, 0);
    @(negedge clk); adv = 1; src_end = 0; dst_end = 0;
    @(negedge clk); adv = 0;
    chk("R9 elem wrap", int'(src_elem), 0);
    // R9 wrap of sub-step, normal order, sub_len 0
    @(negedge clk); src_pack = 0; dst_unpack = 0; sub_len = 2'd0;
    load_both(5, 3, 5, 3);
    @(negedge clk); adv = 1;
    @(negedge clk); adv = 0;
    chk("R9 sub wrap", int'(dst_sub), 0);
    chk("R9 elem unchanged", int'(dst_elem), 5);

    // R8 load wins over advance, one side only
    @(negedge clk); sub_len = 2'd3; adv = 1; src_load = 1;
    src_load_elem = 7'd40; src_load_sub = 2'd1;
    @(negedge clk); src_load = 0; adv = 0;
    chk("R8 load over adv elem", int'(src_elem), 40);
    chk("R8 load over adv sub", int'(src_sub), 1);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      adv        = ($urandom % 4) != 0;
      src_end    = ($urandom % 5) == 0;
      dst_end    = ($urandom % 5) == 0;
      src_pack   = ($urandom % 2) == 1;
      dst_unpack = ($urandom % 2) == 1;
      sub_len    = SW'($urandom % 4);
      src_load   = ($urandom % 16) == 0;
      dst_load   = ($urandom % 16) == 0;
      src_load_elem = EW'($urandom); src_load_sub = SW'($urandom);
      dst_load_elem = EW'($urandom); dst_load_sub = SW'($urandom);
      rst        = ($urandom % 200) == 0;
    end
    @(negedge clk);
    idle_inputs();
    rst = 0;
    // R1 reset overrides load and advance
    @(negedge clk); rst = 1; adv = 1; src_load = 1; src_load_elem = 7'd77;
    @(negedge clk); rst = 0; adv = 0; src_load = 0;
    chk("R1 reset over load", int'(src_elem), 0);
    repeat (2) @(negedge clk);
    done = 1;
    summary();
  end

endmodule